// File: doc/BRIEF.md
# Frame-Synchronous Double-Buffered Control Register Bank

This block holds the run-time parameters of a video processing core in two copies. Software reads and writes a staging copy through a memory-mapped slave port at any time. A working copy drives the datapath. The working copy is reloaded from the staging copy only at a frame boundary, so a frame is never processed with a mix of old and new settings.

The bank watches a ready/valid packet stream that is headed for the datapath. The first beat of each packet carries a type field. Type 0 marks video, and any other value marks a side-band packet. When a video packet's first beat is accepted, all staging parameters are copied into the working set on that same clock edge.

A run flag (`go`) controls whether a new video packet may start. With `go` low, a video packet that is already under way runs to its last beat. The next video header is then held off by the ready signal until `go` returns high. Side-band packets keep flowing in either case. To update the parameters, software clears `go`, writes the new values and sets `go` again. It does not need to wait on the status bit between these steps.

Top module: `ctl_dbuf_bank`

## Requirements
- R1: After reset, `go` is 0, every staging and working parameter is 0, `run_en` is 0 and `rdata` is 0.
- R2: A read (`cs` and `rd` high on an edge) updates `rdata` on that edge, and `rdata` holds otherwise. The address map is as follows. Address 0 returns `go` in bit 0. Address 1 returns status in bit 0. Addresses 2 to 9 return staging parameters 0 to 7 in bits 15:0. Addresses 16 to 23 return working parameters 0 to 7. Every other address, and every unused upper bit, reads as 0.
- R3: A write to a staging parameter (address 2 to 9, bits 15:0 of `wdata`) never changes `act_params` until the next commit.
- R4: A commit happens on the edge where a first beat (`st_sop`) with `st_type` equal to 0 is accepted (`st_valid` and `st_ready` high). On that edge, all eight working parameters take the staging values held before the edge, and `commit` is high during that cycle. `act_params` packs parameter i in bits [16i+15:16i].
- R5: Packets whose first-beat type is not 0 never cause a commit and never set status. They are accepted whatever the value of `go`, with `st_ready` equal to `dp_ready`.
- R6: While `go` is 0, a video first beat sees `st_ready` low, and no commit happens. Once `go` is 1, `st_ready` follows `dp_ready` again.
- R7: If `go` is cleared in the middle of a video packet, the packet's remaining beats still pass with `st_ready` equal to `dp_ready`. The next video header is then held.
- R8: Status and `run_en` are high from the cycle after a multi-beat video packet's first beat is accepted until its last beat (`st_eop`) is accepted. A single-beat video packet commits but leaves them low.
- R9: Writes to address 1, to the working window (16 to 23) or to unmapped addresses change nothing. A write with `cs` low is ignored. Writing address 0 sets `go` from bit 0 of `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Slave select, qualifies rd and wr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| st_valid | input | 1 | Stream beat valid |
| st_sop | input | 1 | Beat is the first of a packet |
| st_eop | input | 1 | Beat is the last of a packet |
| st_type | input | 4 | Packet type on a first beat, 0 means video |
| st_ready | output | 1 | Stream ready towards the source |
| dp_ready | input | 1 | Datapath can take a beat |
| run_en | output | 1 | A video frame is in progress |
| commit | output | 1 | Working set loads on this edge |
| act_params | output | 128 | Working parameters, eight 16-bit fields |

## Verification
A stale working copy appears on `act_params` in the cycle right after the video header is accepted. It is also visible through the read window one read later. A packet tracker stuck in the wrong state shows on `st_ready` at the next video header, which is either wrongly held or wrongly let through. It also shows on `run_en`, which then fails to drop after the last beat. A `go` flag that does not match the model appears as a header that never drains, or one that passes while it should wait.

// File: rtl/ctl_dbuf_pkg.sv
package ctl_dbuf_pkg;
    parameter int NUM_PARAMS = 8;
    parameter int PARAM_W    = 16;
    parameter int ADDR_W     = 5;
    parameter int DATA_W     = 32;
    parameter int TYPE_W     = 4;

    localparam int ADDR_GO     = 0;
    localparam int ADDR_STATUS = 1;
    localparam int ADDR_SHADOW = 2;
    localparam int ADDR_ACTIVE = 16;
    localparam int FLAT_W      = NUM_PARAMS * PARAM_W;

    typedef logic [PARAM_W-1:0]                  param_t;
    typedef logic [NUM_PARAMS-1:0][PARAM_W-1:0]  param_set_t;

    typedef enum logic [1:0] {
        PKT_IDLE  = 2'd0,
        PKT_VIDEO = 2'd1,
        PKT_OTHER = 2'd2
    } pkt_state_e;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [TYPE_W-1:0] ptype;
    } beat_t;

    typedef struct packed {
        logic              cs;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_video(input logic [TYPE_W-1:0] t);
        return t == '0;
    endfunction

    function automatic logic [ADDR_W-1:0] shadow_addr(input int idx);
        return ADDR_W'(ADDR_SHADOW + idx);
    endfunction

    function automatic logic [ADDR_W-1:0] active_addr(input int idx);
        return ADDR_W'(ADDR_ACTIVE + idx);
    endfunction
endpackage

// File: rtl/ctl_regs.sv
module ctl_regs
    import ctl_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              status,
    input  param_set_t        active,
    output logic              go,
    output param_set_t        shadow,
    output logic [DATA_W-1:0] rdata
);
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata_hi;

    assign wr_en           = req.cs & req.wr;
    assign rd_en           = req.cs & req.rd;
    assign unused_wdata_hi = ^req.wdata[DATA_W-1:PARAM_W];

    always_comb begin
        rd_mux = '0;
        if (req.addr == ADDR_W'(ADDR_GO))     rd_mux[0] = go;
        if (req.addr == ADDR_W'(ADDR_STATUS)) rd_mux[0] = status;
        for (int i = 0; i < NUM_PARAMS; i++) begin
            if (req.addr == shadow_addr(i)) rd_mux[PARAM_W-1:0] = shadow[i];
            if (req.addr == active_addr(i)) rd_mux[PARAM_W-1:0] = active[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go     <= 1'b0;
            shadow <= '0;
            rdata  <= '0;
        end else begin
            if (wr_en && req.addr == ADDR_W'(ADDR_GO)) go <= req.wdata[0];
            for (int i = 0; i < NUM_PARAMS; i++) begin
                if (wr_en && req.addr == shadow_addr(i))
                    shadow[i] <= req.wdata[PARAM_W-1:0];
            end
            if (rd_en) rdata <= rd_mux;
        end
    end

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(req.cs && req.rd) |=> $stable(rdata))
        else $error("rdata changed without a read");

    p_go_untouched_r9: assert property (@(posedge clk) disable iff (rst)
        !(req.cs && req.wr && req.addr == ADDR_W'(ADDR_GO)) |=> $stable(go))
        else $error("go changed without a write to its address");
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker
    import ctl_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  logic  dp_ready,
    input  logic  go,
    output logic  st_ready,
    output logic  commit,
    output logic  in_frame
);
    pkt_state_e state_q;
    pkt_state_e state_d;
    logic       video_hdr;
    logic       allow;
    logic       accept;

    assign video_hdr = beat.sop & is_video(beat.ptype);
    assign allow     = ~video_hdr | go;
    assign st_ready  = dp_ready & allow;
    assign accept    = beat.valid & st_ready;
    assign commit    = accept & video_hdr;
    assign in_frame  = (state_q == PKT_VIDEO);

    always_comb begin
        state_d = state_q;
        if (accept) begin
            if (beat.sop) begin
                if (beat.eop)      state_d = PKT_IDLE;
                else if (video_hdr) state_d = PKT_VIDEO;
                else               state_d = PKT_OTHER;
            end else if (beat.eop) begin
                state_d = PKT_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PKT_IDLE;
        else     state_q <= state_d;
    end

    p_commit_needs_go_r6: assert property (@(posedge clk) disable iff (rst)
        commit |-> go)
        else $error("commit while go low");

    p_status_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> $past(commit))
        else $error("frame began without a commit");

    p_sideband_no_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && beat.sop && !is_video(beat.ptype)) |=> !in_frame)
        else $error("side-band packet set status");

    p_frame_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && beat.eop) |=> !in_frame)
        else $error("status stayed high after last beat");
endmodule

// File: rtl/active_bank.sv
module active_bank
    import ctl_dbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  param_set_t shadow,
    output param_set_t active
);
    for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)         active[g] <= '0;
            else if (commit) active[g] <= shadow[g];
        end
    end

    p_load_all_r4: assert property (@(posedge clk) disable iff (rst)
        commit |=> active == $past(shadow))
        else $error("working set not a copy of staging set");

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active))
        else $error("working set changed without a commit");
endmodule

// File: rtl/ctl_dbuf_bank.sv
module ctl_dbuf_bank
    import ctl_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              st_valid,
    input  logic              st_sop,
    input  logic              st_eop,
    input  logic [TYPE_W-1:0] st_type,
    output logic              st_ready,
    input  logic              dp_ready,
    output logic              run_en,
    output logic              commit,
    output logic [FLAT_W-1:0] act_params
);
    bus_req_t   req;
    beat_t      beat;
    logic       go;
    logic       in_frame;
    param_set_t shadow;
    param_set_t active;

    assign req  = '{cs: cs, rd: rd, wr: wr, addr: addr, wdata: wdata};
    assign beat = '{valid: st_valid, sop: st_sop, eop: st_eop, ptype: st_type};

    ctl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .status (in_frame),
        .active (active),
        .go     (go),
        .shadow (shadow),
        .rdata  (rdata)
    );

    frame_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .dp_ready (dp_ready),
        .go       (go),
        .st_ready (st_ready),
        .commit   (commit),
        .in_frame (in_frame)
    );

    active_bank u_act (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .shadow (shadow),
        .active (active)
    );

    assign run_en     = in_frame;
    assign act_params = active;

    p_stream_block_r6: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_sop && st_type == '0 && rdata[0] == 1'b0 && !go) |-> !st_ready)
        else $error("video header passed while go low");
endmodule

// File: tb/ctl_dbuf_bank_bench.sv
`timescale 1ns/1ps
module ctl_dbuf_bank_bench;
    localparam int NP = 8;
    localparam int PW = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         cs, rd, wr;
    logic [4:0]   addr;
    logic [31:0]  wdata;
    logic [31:0]  rdata;
    logic         st_valid, st_sop, st_eop, st_ready, dp_ready;
    logic [3:0]   st_type;
    logic         run_en, commit;
    logic [NP*PW-1:0] act_params;

    int n_cmp = 0;
    int n_bad = 0;
    bit rnd_ready = 1'b0;

    logic [PW-1:0] m_sh  [NP];
    logic [PW-1:0] m_act [NP];
    logic          m_go;
    logic          m_frame;

    always #2.5 clk = ~clk;

    ctl_dbuf_bank u_ctl_dbuf_bank (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .st_valid(st_valid), .st_sop(st_sop),
        .st_eop(st_eop), .st_type(st_type), .st_ready(st_ready),
        .dp_ready(dp_ready), .run_en(run_en), .commit(commit),
        .act_params(act_params)
    );

    function automatic logic [31:0] exp_rd(input int a);
        if (a == 0) return {31'd0, m_go};
        if (a == 1) return {31'd0, m_frame};
        if (a >= 2 && a < 2 + NP) return {16'd0, m_sh[a-2]};
        if (a >= 16 && a < 16 + NP) return {16'd0, m_act[a-16]};
        return 32'd0;
    endfunction

    function automatic logic [NP*PW-1:0] exp_flat();
        logic [NP*PW-1:0] v;
        for (int i = 0; i < NP; i++) v[i*PW +: PW] = m_act[i];
        return v;
    endfunction

    task automatic chk(input string req, input logic [NP*PW-1:0] act, input logic [NP*PW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d, input bit sel = 1'b1);
        @(negedge clk);
        cs = sel; wr = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        if (sel) begin
            if (a == 0) m_go = d[0];
            if (a >= 2 && a < 2 + NP) m_sh[a-2] = d[PW-1:0];
        end
    endtask

    task automatic reg_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = 5'(a);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string req, input int a);
        logic [31:0] v;
        reg_rd(a, v);
        chk(req, {96'd0, v}, {96'd0, exp_rd(a)});
    endtask

    task automatic send_beat(input bit sop, input bit eop, input logic [3:0] typ, output int waits);
        waits = 0;
        @(negedge clk);
        st_valid = 1'b1; st_sop = sop; st_eop = eop; st_type = typ;
        dp_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            dp_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
            #1;
            waits++;
        end
        @(negedge clk);
        st_valid = 1'b0; st_sop = 1'b0; st_eop = 1'b0; dp_ready = 1'b1;
        if (sop && typ == 4'd0) begin
            for (int i = 0; i < NP; i++) m_act[i] = m_sh[i];
            m_frame = !eop;
        end else if (!sop && eop) begin
            m_frame = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w;
        void'($urandom(32'd4242));
        rst = 1'b1; cs = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
        st_valid = 0; st_sop = 0; st_eop = 0; st_type = '0; dp_ready = 1'b1;
        m_go = 0; m_frame = 0;
        for (int i = 0; i < NP; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rdata", {96'd0, rdata}, '0);
        chk("R1 run_en", {127'd0, run_en}, '0);
        chk("R1 act_params", act_params, '0);
        rd_chk("R1 go", 0);
        rd_chk("R1 staging", 2);
        rd_chk("R1 working", 16);

        // R2/R3: staging writes with junk upper bits, working set untouched
        for (int i = 0; i < NP; i++) reg_wr(2 + i, 32'hABCD_0000 | (32'h1100 + i * 32'h0101));
        for (int i = 0; i < NP; i++) rd_chk("R2 staging readback", 2 + i);
        chk("R3 no load before commit", act_params, '0);
        rd_chk("R2 unmapped reads zero", 12);

        // R6: video header held with go low, released when go set; R4 commit
        @(negedge clk);
        st_valid = 1; st_sop = 1; st_eop = 0; st_type = 4'd0; dp_ready = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R6 held while go low", {127'd0, st_ready}, '0);
        end
        rd_chk("R6 status low while held", 1);
        reg_wr(0, 32'd1);
        #1;
        chk("R6 released after go set", {127'd0, st_ready}, 128'd1);
        chk("R4 commit pulse", {127'd0, commit}, 128'd1);
        @(negedge clk);
        st_valid = 0; st_sop = 0; dp_ready = 1;
        for (int i = 0; i < NP; i++) m_act[i] = m_sh[i];
        m_frame = 1;
        chk("R4 working set loaded", act_params, exp_flat());
        chk("R8 run_en in frame", {127'd0, run_en}, 128'd1);
        rd_chk("R8 status read", 1);

        // R3/R7: mid-frame write and go clear
        reg_wr(5, 32'h0000_BEEF);
        chk("R3 mid-frame write held", act_params, exp_flat());
        reg_wr(0, 32'd0);
        send_beat(0, 0, 4'd0, w);
        chk("R7 body passes with go low", w, 0);
        send_beat(0, 1, 4'd0, w);
        chk("R7 last beat passes", w, 0);
        chk("R8 run_en drops", {127'd0, run_en}, '0);
        chk("R3 still old set", act_params, exp_flat());

        // R7: next header held
        @(negedge clk);
        st_valid = 1; st_sop = 1; st_eop = 0; st_type = 4'd0;
        #1;
        chk("R7 next header held", {127'd0, st_ready}, '0);
        @(negedge clk);
        st_valid = 0; st_sop = 0;

        // R5: side-band packet with go low
        send_beat(1, 0, 4'd3, w);
        chk("R5 side-band accepted", w, 0);
        chk("R5 no status", {127'd0, run_en}, '0);
        send_beat(0, 1, 4'd3, w);
        chk("R5 no commit", act_params, exp_flat());

        // R8: single-beat video
        reg_wr(0, 32'd1);
        send_beat(1, 1, 4'd0, w);
        chk("R8 single beat commits", act_params, exp_flat());
        chk("R8 single beat no status", {127'd0, run_en}, '0);

        // R9: ignored writes
        reg_wr(1, 32'hFFFF_FFFF);
        rd_chk("R9 status read-only", 1);
        reg_wr(16, 32'h0000_FFFF);
        rd_chk("R9 working read-only", 16);
        chk("R9 working port unchanged", act_params, exp_flat());
        reg_wr(2, 32'h0000_1234, 1'b0);
        rd_chk("R9 write without cs ignored", 2);
        reg_wr(0, 32'd0);
        rd_chk("R9 go cleared", 0);

        // Random mix
        rnd_ready = 1'b1;
        for (int it = 0; it < 60; it++) begin
            int op = $urandom % 4;
            if (op == 0) begin
                reg_wr(2 + ($urandom % NP), $urandom);
            end else if (op == 1) begin
                reg_wr(0, {31'd0, 1'($urandom)});
            end else if (op == 2) begin
                rd_chk("R2 random read", $urandom % 32);
            end else begin
                bit vid = $urandom % 2;
                int len = 1 + $urandom % 4;
                logic [3:0] t = vid ? 4'd0 : 4'(1 + $urandom % 15);
                if (vid && !m_go) reg_wr(0, 32'd1);
                for (int b = 0; b < len; b++) begin
                    send_beat(b == 0, b == len - 1, t, w);
                    if (b == 0 && len > 1)
                        chk("R8 random status", {127'd0, run_en}, {127'd0, m_frame});
                    if ($urandom % 3 == 0) reg_wr(2 + ($urandom % NP), $urandom);
                    if ($urandom % 4 == 0) reg_wr(0, {31'd0, 1'($urandom)});
                end
                chk("R4 random working set", act_params, exp_flat());
                chk("R8 random end of packet", {127'd0, run_en}, '0);
            end
        end
        for (int i = 0; i < NP; i++) rd_chk("R2 final working window", 16 + i);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule